// File: doc/BRIEF.md
# Key-Protected Scaled Watchdog Timer

This block is a watchdog timer for an always-on power domain. A free-running 31-bit counter advances on a slow tick enable. A 16-bit window of that counter, shifted right by a programmable scale of 0 to 15, is compared against a 16-bit compare value. A match sets a sticky interrupt-pending flag. The configuration can also make a match clear the counter, which gives a periodic interrupt, or issue a one-cycle reset request.

Software reaches the block through a plain 32-bit register port with address, write enable, write data and registered read data. Every write must be preceded by an unlock word written to the key register. The unlock is spent by the very next write to any other address, including a write that is then ignored. The counter can also be restarted by writing a fixed feed word. Byte offsets: config 0x00, counter 0x08, scaled view 0x10, feed 0x18, key 0x1C, compare 0x20. Any other address reads 0.

Top module: `keyed_wdog`

## Requirements
- R1: After the synchronous reset every register is 0, the block is locked, and `bus_rdata`, `irq` and `rst_req` are 0.
- R2: A write of 0x0051F15E to the key offset unlocks the block; a write of any other value there leaves it locked. The key offset reads 1 while unlocked and 0 while locked.
- R3: The unlock is spent by the next write to any address other than the key offset, whether or not that write takes effect. A feed write with the wrong value also relocks the block.
- R4: A write to the config, counter, compare or feed offset while locked changes nothing.
- R5: The counter holds 31 bits. An unlocked write of 0xAAAAAAAA reads back as 0x2AAAAAAA.
- R6: An unlocked write of 0x0D09F00D to the feed offset clears the counter. Any other unlocked feed value leaves the counter unchanged. The feed offset always reads 0.
- R7: Config fields: scale in bits 3:0, reset enable in bit 8, zero-on-match in bit 9, run in bit 12, awake enable in bit 13 (stored and read back only), pending in bit 28. All other bits read 0.
- R8: The scaled view reads bits 15:0 of the counter shifted right by the scale.
- R9: The counter steps by one on each cycle with `tick` high, and only while run is set. With run clear, the counter and scaled view hold.
- R10: While run is set and the scaled view equals the compare value, the pending flag is set on the next edge. If zero-on-match is also set, the counter is cleared on that same edge.
- R11: Pending stays set until an unlocked config write writes bit 28 as 0. When a match and such a clearing write fall on the same edge, the match wins.
- R12: When reset enable is set, `rst_req` is high for exactly one cycle, one cycle after the first cycle of each match run.
- R13: `bus_rdata` is registered: it shows, one cycle later, the value at `bus_addr` as it was before that edge. Counter update priority, from highest to lowest: counter write, feed clear, zero-on-match clear, tick step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Slow-clock tick enable, one cycle per count step |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt pending flag |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Two functions can collide on the same edge. A compare match can meet an unlocked config write that clears pending, and a match with zero-on-match can meet a counter write. The bench provokes the first case by enabling run with reset enable and zero-on-match while the counter and compare are both 0. The match then repeats every cycle, so the clearing write must leave pending at 1, and only a second clear after run drops can succeed. It provokes the second case by writing the counter while the periodic mode is running; the written value must win and then step on the next tick. A behavioural model predicts read data, `irq` and `rst_req` on every cycle, and the bench compares them with the design.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int REG_W       = 32;
  localparam int CFG_SCALE_W = 4;

  localparam int OFS_CFG  = 'h00;
  localparam int OFS_CNT  = 'h08;
  localparam int OFS_SCL  = 'h10;
  localparam int OFS_FEED = 'h18;
  localparam int OFS_KEY  = 'h1C;
  localparam int OFS_CMP  = 'h20;

  localparam logic [REG_W-1:0] UNLOCK_WORD = 32'h0051_F15E;
  localparam logic [REG_W-1:0] FEED_WORD   = 32'h0D09_F00D;

  localparam int BIT_RSTEN = 8;
  localparam int BIT_ZCMP  = 9;
  localparam int BIT_RUN   = 12;
  localparam int BIT_AWAKE = 13;
  localparam int BIT_PEND  = 28;

  typedef struct packed {
    logic                   pend;
    logic                   awake;
    logic                   run;
    logic                   zcmp;
    logic                   rsten;
    logic [CFG_SCALE_W-1:0] scale;
  } cfg_t;
endpackage

// File: rtl/kwd_lock.sv
module kwd_lock (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic key_sel,
  input  logic key_ok,
  output logic unlocked,
  output logic grant
);
  logic unl_q;

  always_ff @(posedge clk) begin
    if (rst)        unl_q <= 1'b0;
    else if (wr_en) unl_q <= key_sel & key_ok;
  end

  assign unlocked = unl_q;
  assign grant    = wr_en & ~key_sel & unl_q;

  // R3: any non-key write spends the unlock
  assert_relock_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en && !key_sel |=> !unlocked);
  // R2: the right word opens the block
  assert_open_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en && key_sel && key_ok |=> unlocked);
  // R2: a wrong key word keeps it shut
  assert_wrongkey_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en && key_sel && !key_ok |=> !unlocked);
endmodule

// File: rtl/kwd_cfg.sv
module kwd_cfg
  import kwd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  cfg_t wr_val,
  input  logic match,
  output cfg_t cfg
);
  cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else begin
      if (wr)    cfg_q <= wr_val;
      if (match) cfg_q.pend <= 1'b1;
    end
  end

  assign cfg = cfg_q;

  // R10: a match raises pending on the next edge
  assert_pend_set_R10: assert property (@(posedge clk) disable iff (rst)
    match |=> cfg.pend);
  // R11: pending is sticky without a config write
  assert_pend_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    cfg.pend && !wr |=> cfg.pend);
  // R4: fields hold when no granted write arrives
  assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable({cfg.scale, cfg.rsten, cfg.zcmp, cfg.run, cfg.awake}));
endmodule

// File: rtl/kwd_core.sv
module kwd_core #(
  parameter int CNT_W   = 31,
  parameter int CMP_W   = 16,
  parameter int SCALE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               run,
  input  logic               zcmp,
  input  logic               rsten,
  input  logic [SCALE_W-1:0] scale,
  input  logic               cnt_wr,
  input  logic [CNT_W-1:0]   cnt_val,
  input  logic               feed,
  input  logic               cmp_wr,
  input  logic [CMP_W-1:0]   cmp_val,
  output logic [CNT_W-1:0]   count,
  output logic [CMP_W-1:0]   scaled,
  output logic [CMP_W-1:0]   cmp,
  output logic               match,
  output logic               rst_req
);
  localparam int STAGES = SCALE_W;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic [CMP_W-1:0] cmp_q;
  logic             match_d, rreq_q;
  logic [CNT_W-1:0] stg [0:STAGES];

  // log-depth right shifter, one stage per scale bit
  assign stg[0] = cnt_q;
  for (genvar i = 0; i < STAGES; i++) begin : g_shift
    assign stg[i+1] = scale[i] ? (stg[i] >> (1 << i)) : stg[i];
  end

  assign scaled = stg[STAGES][CMP_W-1:0];
  assign match  = run & (scaled == cmp_q);

  always_comb begin
    cnt_nx = cnt_q;
    if (cnt_wr)              cnt_nx = cnt_val;
    else if (feed)           cnt_nx = '0;
    else if (match && zcmp)  cnt_nx = '0;
    else if (run && tick)    cnt_nx = cnt_q + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      cmp_q   <= '0;
      match_d <= 1'b0;
      rreq_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_nx;
      match_d <= match;
      rreq_q  <= match & ~match_d & rsten;
      if (cmp_wr) cmp_q <= cmp_val;
    end
  end

  assign count   = cnt_q;
  assign cmp     = cmp_q;
  assign rst_req = rreq_q;

  // R9: frozen while run is clear and nothing writes
  assert_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    !run && !cnt_wr && !feed |=> $stable(count));
  // R9: one step per tick
  assert_step_R9: assert property (@(posedge clk) disable iff (rst)
    run && tick && !match && !cnt_wr && !feed |=> count == $past(count) + ONE);
  // R6: feed clears
  assert_feed_R6: assert property (@(posedge clk) disable iff (rst)
    feed |=> count == '0);
  // R10: zero-on-match clears
  assert_zcmp_R10: assert property (@(posedge clk) disable iff (rst)
    match && zcmp && !cnt_wr |=> count == '0);
  // R12: request follows a match with reset enable
  assert_rreq_R12: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(match) && $past(rsten));
  // R12: one cycle wide
  assert_rreq_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import kwd_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 31,
  parameter int CMP_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              rst_req
);
  localparam int SCALE_W = CFG_SCALE_W;

  logic sel_cfg, sel_cnt, sel_scl, sel_feed, sel_key, sel_cmp;
  logic unlocked, grant, match;
  cfg_t cfg, cfg_new;
  logic [CNT_W-1:0]  count;
  logic [CMP_W-1:0]  scaled, cmp;
  logic [DATA_W-1:0] rd_mux, rd_q;

  assign sel_cfg  = bus_addr == ADDR_W'(OFS_CFG);
  assign sel_cnt  = bus_addr == ADDR_W'(OFS_CNT);
  assign sel_scl  = bus_addr == ADDR_W'(OFS_SCL);
  assign sel_feed = bus_addr == ADDR_W'(OFS_FEED);
  assign sel_key  = bus_addr == ADDR_W'(OFS_KEY);
  assign sel_cmp  = bus_addr == ADDR_W'(OFS_CMP);

  kwd_lock u_lock (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_we),
    .key_sel  (sel_key),
    .key_ok   (bus_wdata == UNLOCK_WORD),
    .unlocked (unlocked),
    .grant    (grant)
  );

  always_comb begin
    cfg_new       = '0;
    cfg_new.scale = bus_wdata[SCALE_W-1:0];
    cfg_new.rsten = bus_wdata[BIT_RSTEN];
    cfg_new.zcmp  = bus_wdata[BIT_ZCMP];
    cfg_new.run   = bus_wdata[BIT_RUN];
    cfg_new.awake = bus_wdata[BIT_AWAKE];
    cfg_new.pend  = bus_wdata[BIT_PEND];
  end

  kwd_cfg u_cfg (
    .clk    (clk),
    .rst    (rst),
    .wr     (grant & sel_cfg),
    .wr_val (cfg_new),
    .match  (match),
    .cfg    (cfg)
  );

  kwd_core #(.CNT_W(CNT_W), .CMP_W(CMP_W), .SCALE_W(SCALE_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .run     (cfg.run),
    .zcmp    (cfg.zcmp),
    .rsten   (cfg.rsten),
    .scale   (cfg.scale),
    .cnt_wr  (grant & sel_cnt),
    .cnt_val (bus_wdata[CNT_W-1:0]),
    .feed    (grant & sel_feed & (bus_wdata == FEED_WORD)),
    .cmp_wr  (grant & sel_cmp),
    .cmp_val (bus_wdata[CMP_W-1:0]),
    .count   (count),
    .scaled  (scaled),
    .cmp     (cmp),
    .match   (match),
    .rst_req (rst_req)
  );

  always_comb begin
    rd_mux = '0;
    if (sel_cfg) begin
      rd_mux[SCALE_W-1:0] = cfg.scale;
      rd_mux[BIT_RSTEN]   = cfg.rsten;
      rd_mux[BIT_ZCMP]    = cfg.zcmp;
      rd_mux[BIT_RUN]     = cfg.run;
      rd_mux[BIT_AWAKE]   = cfg.awake;
      rd_mux[BIT_PEND]    = cfg.pend;
    end
    if (sel_cnt) rd_mux[CNT_W-1:0] = count;
    if (sel_scl) rd_mux[CMP_W-1:0] = scaled;
    if (sel_key) rd_mux[0]         = unlocked;
    if (sel_cmp) rd_mux[CMP_W-1:0] = cmp;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_mux;
  end

  assign bus_rdata = rd_q;
  assign irq       = cfg.pend;

  // R2: key offset reports the lock state seen before the edge
  assert_key_read_R2: assert property (@(posedge clk) disable iff (rst)
    sel_key |=> bus_rdata == {{(DATA_W-1){1'b0}}, $past(unlocked)});
  // R6: feed offset never returns data
  assert_feed_read_R6: assert property (@(posedge clk) disable iff (rst)
    sel_feed |=> bus_rdata == '0);
  // R4: a locked write never reaches the registers
  assert_locked_R4: assert property (@(posedge clk) disable iff (rst)
    bus_we && !unlocked && sel_cmp |=> $stable(cmp));
endmodule

// File: tb/sim_keyed_wdog.sv
module sim_keyed_wdog;
  localparam int KEYA = 'h1C, CFGA = 'h00, CNTA = 'h08, SCLA = 'h10, FEEDA = 'h18, CMPA = 'h20;
  localparam logic [31:0] KEYW = 32'h0051_F15E, FEEDW = 32'h0D09_F00D;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, rst_req;

  keyed_wdog u0 (.clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr), .bus_we(bus_we),
                 .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req));

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit done = 1'b0;

  // behavioural reference model
  bit [30:0] m_cnt; bit [15:0] m_cmp; bit [3:0] m_scale;
  bit m_rsten, m_zcmp, m_run, m_awake, m_pend, m_unl, m_md;
  bit [31:0] e_rdata; bit e_rreq;

  function automatic bit [31:0] cfg_word();
    return {3'b0, m_pend, 14'b0, m_awake, m_run, 2'b0, m_zcmp, m_rsten, 4'b0, m_scale};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_cmp = 0; m_scale = 0; m_rsten = 0; m_zcmp = 0; m_run = 0;
      m_awake = 0; m_pend = 0; m_unl = 0; m_md = 0; e_rdata = 0; e_rreq = 0;
    end else begin
      bit [15:0] sv; bit mt, gr; bit [30:0] nc; int a;
      a  = int'(bus_addr);
      sv = 16'((m_cnt >> m_scale) & 31'hFFFF);
      mt = m_run && (sv == m_cmp);
      case (a)
        CFGA:    e_rdata = cfg_word();
        CNTA:    e_rdata = {1'b0, m_cnt};
        SCLA:    e_rdata = {16'b0, sv};
        KEYA:    e_rdata = {31'b0, m_unl};
        CMPA:    e_rdata = {16'b0, m_cmp};
        default: e_rdata = 0;
      endcase
      e_rreq = mt && !m_md && m_rsten;
      m_md = mt;
      gr = bus_we && a != KEYA && m_unl;
      nc = m_cnt;
      if (gr && a == CNTA) nc = bus_wdata[30:0];
      else if (gr && a == FEEDA && bus_wdata == FEEDW) nc = 0;
      else if (mt && m_zcmp) nc = 0;
      else if (m_run && tick) nc = m_cnt + 1;
      m_cnt = nc;
      if (gr && a == CMPA) m_cmp = bus_wdata[15:0];
      if (gr && a == CFGA) begin
        m_scale = bus_wdata[3:0]; m_rsten = bus_wdata[8]; m_zcmp = bus_wdata[9];
        m_run = bus_wdata[12]; m_awake = bus_wdata[13]; m_pend = bus_wdata[28];
      end
      if (mt) m_pend = 1;
      if (bus_we) m_unl = (a == KEYA) && (bus_wdata == KEYW);
    end
  end

  task automatic check(string t, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check({tag, " rdata"}, bus_rdata, e_rdata);
      check({tag, " irq"}, {31'b0, irq}, {31'b0, m_pend});
      check({tag, " rst_req"}, {31'b0, rst_req}, {31'b0, e_rreq});
    end
  end

  task automatic wr(int a, logic [31:0] d);
    bus_addr = 6'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic uwr(int a, logic [31:0] d);
    wr(KEYA, KEYW);
    wr(a, d);
  endtask

  task automatic rd(int a, output logic [31:0] d);
    bus_addr = 6'(a); bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    int pulses;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tag = "R1";
    check("R1 rdata", bus_rdata, 0); check("R1 irq", {31'b0, irq}, 0);
    check("R1 rst_req", {31'b0, rst_req}, 0);
    rd(CFGA, v); check("R1 cfg", v, 0);
    rd(KEYA, v); check("R1 key", v, 0);

    tag = "R2";
    wr(KEYA, 32'h0000_FFFF); rd(KEYA, v); check("R2 wrong key", v, 0);
    wr(KEYA, KEYW); rd(KEYA, v); check("R2 unlocked", v, 1);
    tag = "R5";
    wr(CNTA, 32'hAAAA_AAAA); rd(CNTA, v); check("R5 count width", v, 32'h2AAA_AAAA);
    tag = "R3";
    rd(KEYA, v); check("R3 relocked", v, 0);

    tag = "R4";
    wr(CNTA, 32'h0000_BEEF); rd(CNTA, v); check("R4 locked count", v, 32'h2AAA_AAAA);
    wr(CFGA, 32'hFFFF_FFFF); rd(CFGA, v); check("R4 locked cfg", v, 0);
    wr(CMPA, 32'h0000_BEEF); rd(CMPA, v); check("R4 locked cmp", v, 0);

    tag = "R6";
    uwr(FEEDA, 32'hAAAA_AAAA); rd(CNTA, v); check("R6 bad feed", v, 32'h2AAA_AAAA);
    rd(KEYA, v); check("R3 bad feed relocks", v, 0);
    uwr(FEEDA, FEEDW); rd(CNTA, v); check("R6 feed clears", v, 0);
    rd(FEEDA, v); check("R6 feed reads 0", v, 0);

    tag = "R7";
    tick = 1'b1;
    uwr(CFGA, 32'hFFFF_FFFF); rd(CFGA, v); check("R7 cfg layout", v, 32'h1000_330F);
    tag = "R11";
    uwr(CFGA, 32'h0); rd(CFGA, v); check("R11 match beats clear", v, 32'h1000_0000);
    uwr(CFGA, 32'h0); rd(CFGA, v); check("R11 clear", v, 0);

    tag = "R8";
    uwr(CNTA, 32'h1234_5678);
    for (int s = 0; s < 16; s++) begin
      uwr(CFGA, 32'(s));
      rd(SCLA, v);
      check($sformatf("R8 scale %0d", s), v, (32'h1234_5678 >> s) & 32'hFFFF);
    end

    tag = "R10";
    uwr(CNTA, 0); uwr(CMPA, 20); uwr(CFGA, 32'h0000_1002);
    repeat (40) @(negedge clk);
    check("R10 no early match", {31'b0, irq}, 0);
    repeat (60) @(negedge clk);
    check("R10 match sets pending", {31'b0, irq}, 1);
    tag = "R11";
    uwr(CFGA, 32'h0000_1002); rd(CFGA, v); check("R11 pending cleared", v, 32'h0000_1002);

    tag = "R9";
    uwr(CFGA, 32'h0000_0002);
    rd(CNTA, v); repeat (20) @(negedge clk); rd(CNTA, v2);
    check("R9 frozen", v2, v);

    tag = "R12";
    uwr(CNTA, 0); uwr(CMPA, 5); uwr(CFGA, 32'h0000_1300);
    pulses = 0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (rst_req) pulses++;
    end
    check("R12 pulses in range", 32'((pulses >= 9) && (pulses <= 11)), 1);
    rd(CNTA, v); check("R10 periodic wrap", 32'(v <= 5), 1);

    tag = "R13";
    uwr(CNTA, 100);
    rd(CNTA, v);  check("R13 write wins", v, 100);
    rd(CNTA, v2); check("R13 then steps", v2, 101);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule